// File: doc/BRIEF.md
# Slot-Rotated Interrupt Pin Router

This block merges the four level-sensitive interrupt pins (A through D) of up to 64 devices onto 16 interrupt-controller input lines. A device reports a change on one of its pins together with its slot number and its device index. The block rotates the pin number by the slot number, so that pin A of neighbouring slots lands on different shared interrupt groups. It keeps one level bit per device for each of the four groups. A group is active while any device's bit for it is set.

Four route registers, one per group, tell which controller line each group drives. A register with its top bit set disables its group. Several groups may share a line, and the line then carries the OR of all of them. Controllers and trigger-mode handling sit outside this block.

Top module: `irq_swizzle_router`

## Requirements
- R1: A level update on pin `lvl_pin` (0=A, 1=B, 2=C, 3=D) from slot `lvl_slot` lands on group (pin + slot + 3) mod 4, which is bit n of `pirq_active` (0=group A … 3=group D).
- R2: Each device holds one level bit per group, written with `lvl_level` on the edge that samples `lvl_valid`. A group is active while at least one device's bit for it is set, and it falls once the last such bit is cleared.
- R3: Level bits of different devices are independent. Clearing one device's bit leaves another device's bit for the same group unchanged.
- R4: An update whose `lvl_dev` is 64 or more changes no level bit. Index 63 is accepted.
- R5: A route write with `rt_we` high stores `rt_wdata` into the route register of group `rt_sel` (0=A … 3=D) on that clock edge, and the other route registers keep their values.
- R6: After reset all level bits are clear, the route of group A is 0x80, and the routes of groups B, C and D are 0x00, which is line 0.
- R7: A group whose route has bit 7 set drives no controller line, whatever its level.
- R8: Controller line k (bit k of `ctl_line`) is high when some active group has bit 7 of its route clear and bits 6:0 of its route equal to k. Route values with bits 6:0 of 16 or more drive no line.
- R9: `pirq_active` and `ctl_line` follow the stored state without further registers. A level update or route write shows on them right after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lvl_valid | input | 1 | A level update is presented this cycle |
| lvl_dev | input | 8 | Device index of the update |
| lvl_slot | input | 5 | Slot number of the reporting device |
| lvl_pin | input | 2 | Interrupt pin of the device, 0=A … 3=D |
| lvl_level | input | 1 | New level of that pin |
| rt_we | input | 1 | Route register write strobe |
| rt_sel | input | 2 | Group whose route register is written |
| rt_wdata | input | 8 | Route value: bit 7 disables, bits 6:0 line number |
| pirq_active | output | 4 | Per-group OR of all device level bits |
| ctl_line | output | 16 | Interrupt-controller line levels |

## Verification
The assertions assume that `lvl_valid` and `rt_we` are only raised once the internal reset release has completed. They also assume that pin, slot and select inputs are known whenever a strobe is high. The bench holds both strobes low through reset and for several cycles after it. It drives every input on the falling edge and keeps each strobe high for exactly one rising edge. It samples results on the next falling edge, so each update is seen once and in isolation.

// File: rtl/irqsw_pkg.sv
package irqsw_pkg;
  localparam int NPIRQ    = 4;
  localparam int PIN_W    = 2;
  localparam int ROUTE_W  = 8;
  localparam int OFF_BIT  = 7;
  localparam logic [ROUTE_W-1:0] ROUTE_A_RST     = 8'h80;
  localparam logic [ROUTE_W-1:0] ROUTE_OTHER_RST = 8'h00;

  typedef logic [PIN_W-1:0] grp_idx_t;

  // Rotation of a device pin by its slot: (pin + slot - 1) mod 4
  function automatic grp_idx_t rotate_pin(input int unsigned pin, input int unsigned slot);
    int unsigned sum;
    sum = pin + slot + NPIRQ - 1;
    return grp_idx_t'(sum % NPIRQ);
  endfunction
endpackage

// File: rtl/irqsw_rst_sync.sv
module irqsw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/irqsw_level_store.sv
module irqsw_level_store
  import irqsw_pkg::*;
#(
  parameter int NDEV  = 64,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  grp_idx_t         upd_grp,
  input  logic             upd_level,
  output logic [NPIRQ-1:0] grp_any
);
  localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic             in_range;
  logic [DEV_W-1:0] dev_sel;

  assign in_range = (int'(upd_idx) < NDEV);
  assign dev_sel  = DEV_W'(upd_idx);

  logic [NDEV-1:0] bits_q [NPIRQ];
  logic [NDEV-1:0] bits_d [NPIRQ];
  logic [NPIRQ-1:0] grp_en;

  for (genvar g = 0; g < NPIRQ; g++) begin : g_grp
    assign grp_en[g] = upd_valid && in_range && (upd_grp == grp_idx_t'(g));

    always_comb begin
      bits_d[g] = bits_q[g];
      if (grp_en[g]) bits_d[g][dev_sel] = upd_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bits_q[g] <= '0;
      else if (grp_en[g]) bits_q[g] <= bits_d[g];
    end

    assign grp_any[g] = |bits_q[g];

    // R4: out-of-range index leaves this group's bits untouched
    assert_oob_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && (int'(upd_idx) >= NDEV)) |=> $stable(bits_q[g]));

    // R2: an accepted update stores the level of that device
    assert_level_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && (int'(upd_idx) < NDEV) && (upd_grp == grp_idx_t'(g)))
        |=> (bits_q[g][$past(dev_sel)] == $past(upd_level)));

    // R3: at most one device bit per group changes per cycle
    assert_single_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(bits_q[g] ^ $past(bits_q[g])) <= 1));
  end
endmodule

// File: rtl/irqsw_route_regs.sv
module irqsw_route_regs
  import irqsw_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  grp_idx_t                        wr_sel,
  input  logic [ROUTE_W-1:0]              wr_data,
  output logic [NPIRQ-1:0][ROUTE_W-1:0]   route_q
);
  logic [NPIRQ-1:0][ROUTE_W-1:0] route_d;
  logic [NPIRQ-1:0]              reg_en;

  for (genvar g = 0; g < NPIRQ; g++) begin : g_reg
    localparam logic [ROUTE_W-1:0] RST_VAL = (g == 0) ? ROUTE_A_RST : ROUTE_OTHER_RST;

    assign reg_en[g] = wr_en && (wr_sel == grp_idx_t'(g));

    always_comb begin
      route_d[g] = route_q[g];
      if (reg_en[g]) route_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         route_q[g] <= RST_VAL;
      else if (reg_en[g]) route_q[g] <= route_d[g];
    end

    // R5: a write to this group lands here
    assert_route_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == grp_idx_t'(g))) |=> (route_q[g] == $past(wr_data)));

    // R5: writes to other groups leave this one alone
    assert_route_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_sel == grp_idx_t'(g))) |=> $stable(route_q[g]));
  end
endmodule

// File: rtl/irqsw_line_merge.sv
module irqsw_line_merge
  import irqsw_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic [NPIRQ-1:0]              grp_any,
  input  logic [NPIRQ-1:0][ROUTE_W-1:0] route,
  output logic [NLINES-1:0]             line_lvl
);
  localparam int NUM_W = ROUTE_W - 1;

  logic [NPIRQ-1:0] grp_live;

  for (genvar p = 0; p < NPIRQ; p++) begin : g_live
    assign grp_live[p] = grp_any[p] && !route[p][OFF_BIT];
  end

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    always_comb begin
      line_lvl[l] = 1'b0;
      for (int p = 0; p < NPIRQ; p++) begin
        if (grp_live[p] && (route[p][NUM_W-1:0] == NUM_W'(l))) line_lvl[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router
  import irqsw_pkg::*;
#(
  parameter int NDEV   = 64,
  parameter int IDX_W  = 8,
  parameter int SLOT_W = 5,
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_valid,
  input  logic [IDX_W-1:0]  lvl_dev,
  input  logic [SLOT_W-1:0] lvl_slot,
  input  logic [1:0]        lvl_pin,
  input  logic              lvl_level,
  input  logic              rt_we,
  input  logic [1:0]        rt_sel,
  input  logic [7:0]        rt_wdata,
  output logic [3:0]        pirq_active,
  output logic [NLINES-1:0] ctl_line
);
  localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic                          srst_n;
  grp_idx_t                      upd_grp;
  logic [NPIRQ-1:0]              grp_any;
  logic [NPIRQ-1:0][ROUTE_W-1:0] route_q;

  irqsw_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign upd_grp = rotate_pin(int'(lvl_pin), int'(lvl_slot));

  irqsw_level_store #(.NDEV(NDEV), .IDX_W(IDX_W)) u_lvl (
    .clk       (clk),
    .rst_n     (srst_n),
    .upd_valid (lvl_valid),
    .upd_idx   (lvl_dev),
    .upd_grp   (upd_grp),
    .upd_level (lvl_level),
    .grp_any   (grp_any)
  );

  irqsw_route_regs u_rt (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (rt_we),
    .wr_sel  (rt_sel),
    .wr_data (rt_wdata),
    .route_q (route_q)
  );

  irqsw_line_merge #(.NLINES(NLINES)) u_merge (
    .grp_any  (grp_any),
    .route    (route_q),
    .line_lvl (ctl_line)
  );

  assign pirq_active = grp_any;

  // R8: any raised line has at least one active group behind it
  assert_line_has_source_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (|ctl_line) |-> (|grp_any));

  for (genvar g = 0; g < NPIRQ; g++) begin : g_chk
    // R8: an active, enabled, in-range group raises its line
    assert_group_drives_line_R8: assert property (@(posedge clk) disable iff (!srst_n)
      (grp_any[g] && !route_q[g][OFF_BIT] && (int'(route_q[g][ROUTE_W-2:0]) < NLINES))
        |-> ctl_line[route_q[g][LINE_W-1:0]]);
  end
endmodule

// File: tb/sim_irq_swizzle_router.sv
module sim_irq_swizzle_router;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lvl_valid, lvl_level, rt_we;
  logic [7:0]  lvl_dev, rt_wdata;
  logic [4:0]  lvl_slot;
  logic [1:0]  lvl_pin, rt_sel;
  logic [3:0]  pirq_active;
  logic [15:0] ctl_line;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_swizzle_router u0 (
    .clk(clk), .rst_n(rst_n), .lvl_valid(lvl_valid), .lvl_dev(lvl_dev),
    .lvl_slot(lvl_slot), .lvl_pin(lvl_pin), .lvl_level(lvl_level),
    .rt_we(rt_we), .rt_sel(rt_sel), .rt_wdata(rt_wdata),
    .pirq_active(pirq_active), .ctl_line(ctl_line)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_level(input int dev, input int slot, input int pin, input bit lvl);
    @(negedge clk);
    lvl_dev = 8'(dev); lvl_slot = 5'(slot); lvl_pin = 2'(pin);
    lvl_level = lvl; lvl_valid = 1'b1;
    @(negedge clk);
    lvl_valid = 1'b0;
  endtask

  task automatic write_route(input int sel, input logic [7:0] val);
    @(negedge clk);
    rt_sel = 2'(sel); rt_wdata = val; rt_we = 1'b1;
    @(negedge clk);
    rt_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R6 reset groups", 32'(pirq_active), 32'h0);
    check("R6 reset lines", 32'(ctl_line), 32'h0);
    set_level(0, 1, 1, 1'b1);                       // group B -> line 0
    check("R1 slot1 pinB", 32'(pirq_active), 32'h2);
    check("R6 group B on line 0", 32'(ctl_line), 32'h1);
    set_level(0, 1, 0, 1'b1);                       // group A disabled at reset
    check("R6 group A active", 32'(pirq_active), 32'h3);
    check("R7 group A off at reset", 32'(ctl_line), 32'h1);
    set_level(0, 1, 1, 1'b0);
    set_level(0, 1, 0, 1'b0);
    check("R2 all cleared", 32'(pirq_active), 32'h0);
  endtask

  task automatic t_swizzle;
    int slots[5] = '{0, 2, 3, 5, 4};
    int pins[5]  = '{0, 3, 1, 2, 1};
    int exps[5]  = '{3, 0, 3, 2, 0};
    for (int i = 0; i < 5; i++) begin
      set_level(7, slots[i], pins[i], 1'b1);
      check($sformatf("R1 slot%0d pin%0d", slots[i], pins[i]),
            32'(pirq_active), 32'(1 << exps[i]));
      set_level(7, slots[i], pins[i], 1'b0);
      check("R2 cleared after swizzle", 32'(pirq_active), 32'h0);
    end
  endtask

  task automatic t_sharing;
    set_level(3, 2, 0, 1'b1);                       // group B
    set_level(10, 1, 1, 1'b1);                      // group B
    check("R2 two devices group B", 32'(pirq_active), 32'h2);
    set_level(3, 2, 0, 1'b0);
    check("R3 other device holds B", 32'(pirq_active), 32'h2);
    set_level(10, 1, 1, 1'b0);
    check("R2 last device cleared", 32'(pirq_active), 32'h0);
  endtask

  task automatic t_oob;
    set_level(64, 1, 0, 1'b1);
    check("R4 index 64 ignored", 32'(pirq_active), 32'h0);
    set_level(255, 1, 2, 1'b1);
    check("R4 index 255 ignored", 32'(pirq_active), 32'h0);
    set_level(63, 1, 2, 1'b1);
    check("R4 index 63 accepted", 32'(pirq_active), 32'h4);
    set_level(127, 1, 2, 1'b0);                     // must not clear device 63
    check("R4 out-of-range clear ignored", 32'(pirq_active), 32'h4);
    set_level(63, 1, 2, 1'b0);
    check("R4 index 63 cleared", 32'(pirq_active), 32'h0);
  endtask

  task automatic t_routes;
    write_route(0, 8'h05);
    write_route(1, 8'h05);
    write_route(2, 8'h8C);
    write_route(3, 8'h0A);
    set_level(1, 1, 0, 1'b1);                       // group A
    check("R5 A to line 5", 32'(ctl_line), 32'h0020);
    set_level(2, 1, 1, 1'b1);                       // group B
    check("R8 A and B share line 5", 32'(ctl_line), 32'h0020);
    set_level(1, 1, 0, 1'b0);
    check("R8 B keeps line 5", 32'(ctl_line), 32'h0020);
    set_level(2, 1, 1, 1'b0);
    check("R8 line 5 falls", 32'(ctl_line), 32'h0);
    set_level(4, 1, 2, 1'b1);                       // group C, disabled
    check("R7 group C active", 32'(pirq_active), 32'h4);
    check("R7 disabled drives nothing", 32'(ctl_line), 32'h0);
    set_level(4, 1, 3, 1'b1);                       // group D -> line 10
    check("R8 D to line 10", 32'(ctl_line), 32'h0400);
    write_route(3, 8'h03);
    check("R9 D moved to line 3", 32'(ctl_line), 32'h0008);
    write_route(3, 8'h15);
    check("R8 route 0x15 no line", 32'(ctl_line), 32'h0);
    write_route(2, 8'h03);
    check("R5 C enabled on line 3", 32'(ctl_line), 32'h0008);
    set_level(4, 1, 2, 1'b0);
    set_level(4, 1, 3, 1'b0);
    check("R9 all quiet", 32'(ctl_line), 32'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lvl_valid = 1'b0; lvl_level = 1'b0; rt_we = 1'b0;
    lvl_dev = '0; lvl_slot = '0; lvl_pin = '0; rt_sel = '0; rt_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_swizzle();
    t_sharing();
    t_oob();
    t_routes();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule